// File: doc/BRIEF.md
# Strided Vector Load Sequencer

This block performs a single strided load of 64-bit elements into a register buffer of a fixed number of element slots. A start command gives a base byte address, a signed byte stride, an active vector length, a flag that switches element masking off, a per-element mask vector, and two fill-policy bits. The block works out which elements are active. It issues one 8-byte read request for each active element over a valid/ready handshake, in ascending element order. Each returned word goes into the slot of the element it belongs to.

The stride is applied as a raw byte count with no scaling, so a zero stride reads the same address again and again and a negative stride walks downward. Address arithmetic wraps at 64 bits. Slots that receive no data keep their old contents or are set to all ones, depending on the policy bits. Masked-off body slots follow one bit and slots at or above the vector length follow the other. When every active response has been written, a one-cycle done pulse ends the command. The buffer contents are visible at all times on a flat output.

Top module: `stride_load_seq`

## Requirements
- R1: After reset the block is idle: busy_o, req_valid_o and done_o are 0 and every buffer slot reads zero.
- R2: The request for element i carries the address base + i × stride modulo 2^64, where the stride is a two's-complement byte count used unscaled; zero and negative strides are legal.
- R3: Requests are issued only for active elements, in ascending element index, one per handshake (req_valid_o and req_ready_i both 1 at a clock edge); while req_valid_o is 1 and req_ready_i is 0, the request address holds.
- R4: An element i below vl is active when unmasked_i is 1, or when unmasked_i is 0 and mask_i[i] is 1.
- R5: Responses arrive in request order; each rsp_valid_i cycle writes rsp_data_i into the slot of the oldest request not yet answered (slot i occupies buf_o bits 64·i+63 down to 64·i).
- R6: A body element that is not active is set to all ones when mask_agn_i is 1 at start, and is left unchanged when it is 0.
- R7: Every slot with index at or above vl is set to all ones when tail_agn_i is 1 at start, and is left unchanged when it is 0.
- R8: done_o is high for exactly one cycle, the cycle after the last active response is written; busy_o falls at the following edge and no request is pending while done_o is high.
- R9: A start with vl = 0, or with no active element, issues no request and raises done_o in the cycle after the start is taken.
- R10: A start asserted while busy_o is 1 is ignored and changes neither the request stream nor the buffer.
- R11: A vl larger than the number of slots makes every slot a body element, with no tail slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a command (taken only when idle) |
| base_i | input | 64 | Base byte address |
| stride_i | input | 64 | Signed byte stride |
| vl_i | input | 4 | Active vector length |
| unmasked_i | input | 1 | 1: all body elements active; 0: mask_i selects |
| mask_i | input | 8 | Per-element mask bits |
| mask_agn_i | input | 1 | Inactive body fill: 1 all ones, 0 keep |
| tail_agn_i | input | 1 | Tail fill: 1 all ones, 0 keep |
| busy_o | output | 1 | Command in progress |
| req_valid_o | output | 1 | Read request valid |
| req_ready_i | input | 1 | Read request accepted |
| req_addr_o | output | 64 | Read request byte address |
| rsp_valid_i | input | 1 | Read response valid |
| rsp_data_i | input | 64 | Read response data |
| done_o | output | 1 | One-cycle completion pulse |
| buf_o | output | 512 | Flat buffer contents, slot 0 in the low bits |

## Verification
The assertions assume that the memory side never answers a request before it has been accepted and always answers in request order, so every response has a pending slot. They also assume a start is only meaningful while the block is idle. The stimulus keeps to this: responses are driven only while the bench's own queue of accepted requests is non-empty, and always for its oldest entry. Starts raised during a busy command are deliberate probes of the ignore rule, and the bench expects no effect from them.

// File: rtl/sld_pkg.sv
package sld_pkg;
   localparam int unsigned ELEM_BITS = 64;
   typedef logic [ELEM_BITS-1:0] elem_t;
   typedef enum logic {SLD_IDLE = 1'b0, SLD_RUN = 1'b1} sld_state_e;
endpackage

// File: rtl/sld_pick.sv
// Lowest-set-bit selector: index of the first pending element.
module sld_pick #(
   parameter int unsigned N     = 8,
   localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     vec_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             any_o
);
   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec_i[i]) idx_o = IDX_W'(i);
      end
      any_o = |vec_i;
   end
endmodule

// File: rtl/sld_agen.sv
// Element address: base + idx * stride, wrapping at ADDR_W bits.
module sld_agen #(
   parameter int unsigned ADDR_W  = 64,
   parameter int unsigned IDX_W   = 3,
   parameter bit          SHIFT_ADD = 1'b1
) (
   input  logic [ADDR_W-1:0] base_i,
   input  logic [ADDR_W-1:0] stride_i,
   input  logic [IDX_W-1:0]  idx_i,
   output logic [ADDR_W-1:0] addr_o
);
   generate
      if (SHIFT_ADD) begin : g_shift_add
         logic [ADDR_W-1:0] acc [IDX_W+1];
         assign acc[0] = base_i;
         for (genvar b = 0; b < IDX_W; b++) begin : g_bit
            assign acc[b+1] = acc[b] + (idx_i[b] ? (stride_i << b) : '0);
         end
         assign addr_o = acc[IDX_W];
      end else begin : g_mul
         assign addr_o = base_i + stride_i * ADDR_W'(idx_i);
      end
   endgenerate
endmodule

// File: rtl/sld_elem_buf.sv
// Element slot storage with start-time policy fill and response writes.
module sld_elem_buf #(
   parameter int unsigned N      = 8,
   parameter int unsigned DATA_W = 64,
   localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              fill_en_i,
   input  logic [N-1:0]      fill_vec_i,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [N*DATA_W-1:0] data_o
);
   generate
      for (genvar s = 0; s < N; s++) begin : g_slot
         logic [DATA_W-1:0] slot_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               slot_q <= '0;
            end else if (fill_en_i && fill_vec_i[s]) begin
               slot_q <= '1;
            end else if (wr_en_i && (wr_idx_i == IDX_W'(s))) begin
               slot_q <= wr_data_i;
            end
         end
         assign data_o[s*DATA_W +: DATA_W] = slot_q;
      end
   endgenerate
endmodule

// File: rtl/stride_load_seq.sv
module stride_load_seq
   import sld_pkg::*;
#(
   parameter int unsigned ELEMS     = 8,
   parameter int unsigned ADDR_W    = 64,
   parameter int unsigned DATA_W    = 64,
   parameter bit          SHIFT_ADD = 1'b1,
   localparam int unsigned VL_W  = $clog2(ELEMS + 1),
   localparam int unsigned IDX_W = (ELEMS > 1) ? $clog2(ELEMS) : 1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  start_i,
   input  logic [ADDR_W-1:0]     base_i,
   input  logic [ADDR_W-1:0]     stride_i,
   input  logic [VL_W-1:0]       vl_i,
   input  logic                  unmasked_i,
   input  logic [ELEMS-1:0]      mask_i,
   input  logic                  mask_agn_i,
   input  logic                  tail_agn_i,
   output logic                  busy_o,
   output logic                  req_valid_o,
   input  logic                  req_ready_i,
   output logic [ADDR_W-1:0]     req_addr_o,
   input  logic                  rsp_valid_i,
   input  logic [DATA_W-1:0]     rsp_data_i,
   output logic                  done_o,
   output logic [ELEMS*DATA_W-1:0] buf_o
);
   generate
      if (ELEMS < 1) begin : g_bad_elems
         $error("stride_load_seq: ELEMS must be at least 1");
      end
      if (DATA_W != ELEM_BITS) begin : g_bad_data
         $error("stride_load_seq: elements are fixed at 64 bits");
      end
      if (ADDR_W < 8) begin : g_bad_addr
         $error("stride_load_seq: ADDR_W too narrow");
      end
   endgenerate

   sld_state_e        state_q;
   logic [ADDR_W-1:0] base_q, stride_q;
   logic [ELEMS-1:0]  iss_pend_q, rsp_pend_q;
   logic [ELEMS-1:0]  act_vec, fill_vec;
   logic [IDX_W-1:0]  iss_idx, rsp_idx;
   logic              iss_any, rsp_any;
   logic              accept, running, req_fire, rsp_fire;

   // Classify slots from the start command.
   always_comb begin
      for (int i = 0; i < ELEMS; i++) begin
         if (VL_W'(i) < vl_i) begin
            act_vec[i]  = unmasked_i | mask_i[i];
            fill_vec[i] = ~act_vec[i] & mask_agn_i;
         end else begin
            act_vec[i]  = 1'b0;
            fill_vec[i] = tail_agn_i;
         end
      end
   end

   assign running = (state_q == SLD_RUN);
   assign accept  = start_i & ~running;

   sld_pick #(.N(ELEMS)) u_iss_pick (.vec_i(iss_pend_q), .idx_o(iss_idx), .any_o(iss_any));
   sld_pick #(.N(ELEMS)) u_rsp_pick (.vec_i(rsp_pend_q), .idx_o(rsp_idx), .any_o(rsp_any));

   sld_agen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SHIFT_ADD(SHIFT_ADD)) u_agen (
      .base_i  (base_q),
      .stride_i(stride_q),
      .idx_i   (iss_idx),
      .addr_o  (req_addr_o)
   );

   assign req_valid_o = running & iss_any;
   assign req_fire    = req_valid_o & req_ready_i;
   assign rsp_fire    = running & rsp_valid_i & rsp_any;
   assign done_o      = running & ~rsp_any;
   assign busy_o      = running;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q    <= SLD_IDLE;
         base_q     <= '0;
         stride_q   <= '0;
         iss_pend_q <= '0;
         rsp_pend_q <= '0;
      end else if (accept) begin
         state_q    <= SLD_RUN;
         base_q     <= base_i;
         stride_q   <= stride_i;
         iss_pend_q <= act_vec;
         rsp_pend_q <= act_vec;
      end else if (running) begin
         if (req_fire) iss_pend_q <= iss_pend_q & ~(ELEMS'(1) << iss_idx);
         if (rsp_fire) rsp_pend_q <= rsp_pend_q & ~(ELEMS'(1) << rsp_idx);
         if (done_o)   state_q    <= SLD_IDLE;
      end
   end

   sld_elem_buf #(.N(ELEMS), .DATA_W(DATA_W)) u_buf (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .fill_en_i (accept),
      .fill_vec_i(fill_vec),
      .wr_en_i   (rsp_fire),
      .wr_idx_i  (rsp_idx),
      .wr_data_i (rsp_data_i),
      .data_o    (buf_o)
   );
endmodule

// File: rtl/sld_chk.sv
module sld_chk #(
   parameter int unsigned ADDR_W = 64,
   parameter int unsigned VL_W   = 4
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              start_i,
   input logic [VL_W-1:0]   vl_i,
   input logic              busy_o,
   input logic              req_valid_o,
   input logic              req_ready_i,
   input logic [ADDR_W-1:0] req_addr_o,
   input logic              done_o
);
   p_idle_no_req_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> !req_valid_o);

   p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));

   p_done_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   p_done_ends_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !busy_o);

   p_done_no_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> !req_valid_o);

   p_empty_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !busy_o && vl_i == '0) |=> done_o);

   p_start_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && busy_o && !done_o) |=> busy_o);
endmodule

bind stride_load_seq sld_chk #(.ADDR_W(ADDR_W), .VL_W(VL_W)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .start_i    (start_i),
   .vl_i       (vl_i),
   .busy_o     (busy_o),
   .req_valid_o(req_valid_o),
   .req_ready_i(req_ready_i),
   .req_addr_o (req_addr_o),
   .done_o     (done_o)
);

// File: tb/stride_load_seq_tb_top.sv
`timescale 1ns/1ps
module stride_load_seq_tb_top;
   localparam int N = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic          start;
   logic [63:0]   base, stride;
   logic [3:0]    vl;
   logic          unm, magn, tagn;
   logic [N-1:0]  mask;
   logic          busy, req_valid, req_ready, rsp_valid, done;
   logic [63:0]   req_addr, rsp_data;
   logic [N*64-1:0] bufv;

   stride_load_seq dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base), .stride_i(stride),
      .vl_i(vl), .unmasked_i(unm), .mask_i(mask), .mask_agn_i(magn), .tail_agn_i(tagn),
      .busy_o(busy), .req_valid_o(req_valid), .req_ready_i(req_ready), .req_addr_o(req_addr),
      .rsp_valid_i(rsp_valid), .rsp_data_i(rsp_data), .done_o(done), .buf_o(bufv)
   );

   int vecs = 0, errs = 0;
   int cmd_id = 0;
   int rdy_mode = 0, rsp_mode = 0;
   logic [15:0] lfsr = 16'hACE1;

   // reference model state
   bit          m_busy = 0;
   logic [63:0] m_buf [N];
   logic [63:0] m_base = '0, m_stride = '0;
   int          q_iss[$];
   int          q_out[$];

   // command fields for the next start
   logic [63:0] c_base, c_stride;
   logic [3:0]  c_vl;
   logic        c_unm, c_magn, c_tagn;
   logic [N-1:0] c_mask;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [63:0] elem_addr(input int idx);
      return m_base + m_stride * 64'(idx);
   endfunction

   // One clock: compare, drive, advance the model to the next edge.
   task automatic step(input bit st);
      bit exp_v, done_now, acc, fire_req, fire_rsp;
      @(negedge clk);
      exp_v    = m_busy && q_iss.size() > 0;
      done_now = m_busy && q_iss.size() == 0 && q_out.size() == 0;
      chk("R3 req_valid", 64'(req_valid), 64'(exp_v));
      if (exp_v) chk("R2 req_addr", req_addr, elem_addr(q_iss[0]));
      chk("R8 done", 64'(done), 64'(done_now));
      chk("R10 busy", 64'(busy), 64'(m_busy));
      for (int i = 0; i < N; i++) chk("R5/R6/R7 slot", bufv[i*64 +: 64], m_buf[i]);

      start = st; base = c_base; stride = c_stride; vl = c_vl;
      unm = c_unm; mask = c_mask; magn = c_magn; tagn = c_tagn;
      req_ready = (rdy_mode == 0) ? 1'b1 : lfsr[0];
      fire_rsp  = q_out.size() > 0 && (rsp_mode == 0 || lfsr[3]);
      rsp_valid = fire_rsp;
      rsp_data  = fire_rsp ? (elem_addr(q_out[0]) ^ 64'h5A5A_C3C3_0F0F_9696 ^ 64'(cmd_id << 40))
                           : 64'hDEAD_BEEF_0000_0000;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

      acc      = st && !m_busy;
      fire_req = exp_v && req_ready;
      if (fire_rsp) m_buf[q_out.pop_front()] = rsp_data;
      if (fire_req) q_out.push_back(q_iss.pop_front());
      if (done_now) m_busy = 0;
      if (acc) begin
         m_busy = 1; m_base = c_base; m_stride = c_stride; cmd_id++;
         for (int i = 0; i < N; i++) begin
            if (i < int'(c_vl)) begin
               if (c_unm || c_mask[i]) q_iss.push_back(i);   // R4
               else if (c_magn) m_buf[i] = '1;               // R6
            end else if (c_tagn) m_buf[i] = '1;              // R7
         end
      end
   endtask

   task automatic run_cmd(input logic [63:0] b, input logic [63:0] s, input logic [3:0] v,
                          input logic u, input logic [N-1:0] mk, input logic ma,
                          input logic ta, input bit poke);
      bit hung = 1;
      c_base = b; c_stride = s; c_vl = v; c_unm = u; c_mask = mk; c_magn = ma; c_tagn = ta;
      step(1);
      for (int k = 0; k < 400; k++) begin
         if (!m_busy) begin hung = 0; break; end
         if (poke && k == 1) begin
            // R10: different command while busy
            c_base = 64'h7777_0000; c_stride = 64'd1; c_vl = 4'd8; c_unm = 1'b1;
            c_magn = 1'b1; c_tagn = 1'b1;
         end
         step(poke && k == 1);
      end
      if (hung) begin
         errs++;
         $display("FAIL R8 watchdog: command never completed actual=busy expected=idle");
      end
      step(0); step(0);
   endtask

   initial begin
      #(200000 * 4);
      errs++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) m_buf[i] = '0;
      c_base = '0; c_stride = '0; c_vl = '0; c_unm = 0; c_mask = '0; c_magn = 0; c_tagn = 0;
      start = 0; base = '0; stride = '0; vl = '0; unm = 0; mask = '0; magn = 0; tagn = 0;
      req_ready = 0; rsp_valid = 0; rsp_data = '0;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 busy", 64'(busy), 64'd0);
      chk("R1 req_valid", 64'(req_valid), 64'd0);
      chk("R1 done", 64'(done), 64'd0);
      chk("R1 buf", 64'(|bufv), 64'd0);
      rst_n = 1'b1;
      step(0); step(0);

      // R2/R3: ascending, unmasked, stride 8
      run_cmd(64'h1000, 64'd8, 4'd8, 1'b1, 8'h00, 1'b0, 1'b0, 0);
      // R2: zero stride, R7 tail all ones, stalling ready
      rdy_mode = 1; rsp_mode = 1;
      run_cmd(64'h2000, 64'd0, 4'd5, 1'b1, 8'h00, 1'b0, 1'b1, 0);
      // R2 negative stride, R4 mask select, R6 undisturbed, R10 poke
      run_cmd(64'h3000, 64'hFFFF_FFFF_FFFF_FFE8, 4'd7, 1'b0, 8'b1011_0110, 1'b0, 1'b0, 1);
      // R2 wrap at 2^64, R6 agnostic fill
      run_cmd(64'hFFFF_FFFF_FFFF_FFF0, 64'd16, 4'd8, 1'b0, 8'h55, 1'b1, 1'b0, 0);
      // R2 odd unscaled stride
      rdy_mode = 0;
      run_cmd(64'h4001, 64'd3, 4'd6, 1'b0, 8'hFF, 1'b1, 1'b0, 0);
      // R9 empty vector: tail undisturbed, then agnostic
      run_cmd(64'h5000, 64'd8, 4'd0, 1'b1, 8'hFF, 1'b1, 1'b0, 0);
      run_cmd(64'h5000, 64'd8, 4'd0, 1'b1, 8'hFF, 1'b0, 1'b1, 0);
      // R9 no active element although vl > 0
      run_cmd(64'h6000, 64'd8, 4'd4, 1'b0, 8'h00, 1'b0, 1'b1, 0);
      // R11 vl beyond slot count
      rsp_mode = 0; rdy_mode = 1;
      run_cmd(64'h7000, 64'hFFFF_FFFF_FFFF_FFF8, 4'd12, 1'b1, 8'h00, 1'b0, 1'b1, 1);

      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
   end
endmodule